// File: doc/BRIEF.md
# Key-Restarted Watchdog Timer

This block is a down-counting watchdog behind a small word-wide register port. Software picks one of sixteen timeout lengths, each a power of two in clock cycles, then arms the counter. Once armed, the counter cannot be stopped by software. Only the block reset stops it.

To keep the system alive, software must write a fixed key word to the restart register before the count runs out. Any other value written there is discarded. The live count can be read at any time. When the count reaches zero, the block raises a single-cycle reset request, reloads itself and keeps running.

The base exponent of the period is a parameter, 16 by default. A smaller value shortens every timeout for simulation. The period decoder comes in two variants, a shifter or a per-index compare, and a parameter picks between them.

Top module: `wdog_timer`

## Requirements
- R1: After reset, the arm bit reads 0, the timeout index reads 0, the count reads 2^BASE_SHIFT, and `rst_req` is low.
- R2: A write to offset 0x00 with data bit 0 set arms the counter. Reading offset 0x00 returns the arm state in bit 0. Writing 0 there never disarms it; only reset does.
- R3: A write to offset 0x04 stores data bits [3:0] as the timeout index. Reading offset 0x04 returns the index in bits [3:0] and zero in all other bits.
- R4: The period for index i is 2^(BASE_SHIFT+i) cycles. It is loaded into the counter on the cycle the arm bit goes from 0 to 1.
- R5: While armed, the counter decreases by one every cycle. While disarmed, it holds its value unless a valid restart arrives.
- R6: A read request (`req_valid` high, `req_write` low) updates `rd_data` one cycle later. For offset 0x08, the value is the count as it stood in the request cycle. Unmapped offsets and offset 0x0C read as 0.
- R7: A write to offset 0x0C of exactly 0x00000076 reloads the counter with the period of the current index. A write there with any other value leaves the count running unchanged.
- R8: When the armed counter is zero, `rst_req` is high for exactly one cycle and the counter reloads. Consecutive requests are therefore 2^(BASE_SHIFT+i)+1 cycles apart.
- R9: Writing a new timeout index does not change the running count. The new period is used only from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (4) | Byte offset of the register |
| req_wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, valid the cycle after a read request |
| rst_req | output | 1 | Single-cycle system reset request on expiry |

## Verification
The assertions assume the following about the inputs:
- At most one register access happens per cycle.
- `req_wdata` and `req_addr` are known whenever `req_valid` is high.
- BASE_SHIFT is at least 1, so a reload never leaves the counter at zero. This keeps the reset request from occurring on two cycles in a row.

The bench drives all inputs on the falling edge, one access at a time, and leaves `req_valid` low between accesses. It uses BASE_SHIFT of 4 so that several full expiries fit in a short run. The largest index is checked through the reloaded count rather than by waiting it out.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // register offsets (byte addresses on the request port)
   localparam logic [7:0] OFS_ARM   = 8'h00;
   localparam logic [7:0] OFS_TOSEL = 8'h04;
   localparam logic [7:0] OFS_COUNT = 8'h08;
   localparam logic [7:0] OFS_KICK  = 8'h0C;

   // full-word value that restarts the count
   localparam logic [31:0] KICK_KEY = 32'h0000_0076;

   // period decoder variants
   localparam int PSTYLE_SHIFT   = 0;
   localparam int PSTYLE_COMPARE = 1;

   // one-cycle events passed from the register file to the counter
   typedef struct packed {
      logic arm_rise;
      logic kick;
   } wdog_evt_t;

endpackage

// File: rtl/wdog_period.sv
module wdog_period #(
   parameter int IDX_W       = 4,
   parameter int BASE_SHIFT  = 16,
   parameter int CNT_W       = BASE_SHIFT + (1 << IDX_W),
   parameter int PERIOD_STYLE = wdog_pkg::PSTYLE_SHIFT
) (
   input  logic [IDX_W-1:0] idx,
   output logic [CNT_W-1:0] period
);
   localparam int NUM_IDX = 1 << IDX_W;

   if (BASE_SHIFT + NUM_IDX > CNT_W) begin : g_bad_width
      $error("wdog_period: CNT_W too small for the largest period");
   end

   if (PERIOD_STYLE == wdog_pkg::PSTYLE_SHIFT) begin : g_shift
      always_comb begin
         period = CNT_W'(1) << (BASE_SHIFT + int'(idx));
      end
   end else begin : g_compare
      always_comb begin
         period = '0;
         for (int i = 0; i < NUM_IDX; i++) begin
            if (idx == IDX_W'(i)) period[BASE_SHIFT + i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int IDX_W  = 4,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]  cnt_value,
   output logic              arm_q,
   output logic [IDX_W-1:0]  idx_q,
   output wdog_evt_t         evt,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] A_ARM   = OFS_ARM[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_TOSEL = OFS_TOSEL[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_COUNT = OFS_COUNT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_KICK  = OFS_KICK[ADDR_W-1:0];

   logic              wr_req, rd_req;
   logic              hit_arm, hit_tosel, hit_count, hit_kick;
   logic [DATA_W-1:0] rd_mux;

   assign wr_req    = req_valid &  req_write;
   assign rd_req    = req_valid & ~req_write;
   assign hit_arm   = (req_addr == A_ARM);
   assign hit_tosel = (req_addr == A_TOSEL);
   assign hit_count = (req_addr == A_COUNT);
   assign hit_kick  = (req_addr == A_KICK);

   always_comb begin
      evt.arm_rise = wr_req & hit_arm & req_wdata[0] & ~arm_q;
      evt.kick     = wr_req & hit_kick & (req_wdata == DATA_W'(KICK_KEY));
   end

   always_comb begin
      rd_mux = '0;
      if (hit_arm)        rd_mux[0]         = arm_q;
      else if (hit_tosel) rd_mux[IDX_W-1:0] = idx_q;
      else if (hit_count) rd_mux[CNT_W-1:0] = cnt_value;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q   <= 1'b0;
         idx_q   <= '0;
         rd_data <= '0;
      end else begin
         if (evt.arm_rise)          arm_q   <= 1'b1;
         if (wr_req && hit_tosel)   idx_q   <= req_wdata[IDX_W-1:0];
         if (rd_req)                rd_data <= rd_mux;
      end
   end

   AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      arm_q |=> arm_q);  // R2
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(rd_data));  // R6

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int BASE_SHIFT = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  wdog_evt_t        evt,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire_q
);
   localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(1) << BASE_SHIFT;

   logic at_zero, expire_now, reload;

   assign at_zero    = (cnt_q == '0);
   assign expire_now = arm & at_zero;
   assign reload     = expire_now | evt.kick | evt.arm_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= RST_CNT;
         expire_q <= 1'b0;
      end else begin
         expire_q <= expire_now;
         if (reload)   cnt_q <= period;
         else if (arm) cnt_q <= cnt_q - 1'b1;
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !evt.kick && !evt.arm_rise) |=> $stable(cnt_q));  // R5
   AST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !at_zero && !evt.kick) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R5
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      expire_q |=> !expire_q);  // R8
   AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && at_zero) |=> (expire_q && cnt_q == $past(period)));  // R8
   AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      evt.kick |=> (cnt_q == $past(period)));  // R7
   AST_LOAD_POW2: assert property (@(posedge clk) disable iff (!rst_n)
      evt.arm_rise |=> ($countones(cnt_q) == 1));  // R4

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter int IDX_W        = 4,
   parameter int BASE_SHIFT   = 16,
   parameter int PERIOD_STYLE = PSTYLE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req
);
   localparam int NUM_IDX = 1 << IDX_W;
   localparam int CNT_W   = BASE_SHIFT + NUM_IDX;

   if (CNT_W > DATA_W) begin : g_bad_data
      $error("wdog_timer: count does not fit the data word");
   end
   if (BASE_SHIFT < 1) begin : g_bad_shift
      $error("wdog_timer: BASE_SHIFT must be at least 1");
   end
   if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
      $error("wdog_timer: ADDR_W must be 4 to 8");
   end
   if (DATA_W < 32) begin : g_bad_key
      $error("wdog_timer: DATA_W must hold the restart key");
   end

   logic             arm_q;
   logic [IDX_W-1:0] idx_q;
   wdog_evt_t        evt;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] cnt_q;

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .cnt_value(cnt_q),
      .arm_q(arm_q), .idx_q(idx_q), .evt(evt), .rd_data(rd_data)
   );

   wdog_period #(
      .IDX_W(IDX_W), .BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W),
      .PERIOD_STYLE(PERIOD_STYLE)
   ) u_period (
      .idx(idx_q), .period(period)
   );

   wdog_counter #(
      .CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)
   ) u_counter (
      .clk(clk), .rst_n(rst_n), .arm(arm_q), .evt(evt),
      .period(period), .cnt_q(cnt_q), .expire_q(rst_req)
   );

endmodule

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
   localparam int BS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wdog_timer #(.BASE_SHIFT(BS), .PERIOD_STYLE(1)) u_wdog_timer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_data(rd_data), .rst_req(rst_req)
   );

   // behavioural reference, updated on every rising edge
   bit      m_arm;
   int      m_idx;
   longint  m_cnt;
   bit      m_req;
   longint  m_rd;

   function automatic longint per(int i);
      return longint'(1) << (BS + i);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_arm = 0; m_idx = 0; m_cnt = per(0); m_req = 0; m_rd = 0;
      end else begin
         bit     wr, expire, kick, rise;
         longint nxt;
         wr     = req_valid && req_write;
         expire = m_arm && (m_cnt == 0);
         kick   = wr && req_addr == 4'hC && req_wdata == 32'h76;
         rise   = wr && req_addr == 4'h0 && req_wdata[0] && !m_arm;
         if (req_valid && !req_write) begin
            case (req_addr)
               4'h0: m_rd = m_arm ? 1 : 0;
               4'h4: m_rd = m_idx;
               4'h8: m_rd = m_cnt;
               default: m_rd = 0;
            endcase
         end
         if (expire || kick || rise) nxt = per(m_idx);
         else if (m_arm)             nxt = m_cnt - 1;
         else                        nxt = m_cnt;
         m_req = expire;
         m_cnt = nxt;
         if (rise) m_arm = 1;
         if (wr && req_addr == 4'h4) m_idx = int'(req_wdata[3:0]);
      end
   end

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // compare outputs with the reference on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(rst_req == m_req, "R8 rst_req per-cycle", rst_req, m_req);
         chk(longint'(rd_data) == m_rd, "R6 rd_data per-cycle", rd_data, m_rd);
      end
   end

   task automatic wr(logic [3:0] a, logic [31:0] d);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_write = 0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] v);
      req_valid = 1; req_write = 0; req_addr = a;
      @(negedge clk);
      req_valid = 0;
      v = rd_data;
   endtask

   task automatic wait_pulse(output int n);
      n = 0;
      while (!rst_req && n < 400) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(rst_req == 0, "R1 rst_req low", rst_req, 0);
      rd(4'h0, v); chk(v == 0, "R1 arm after reset", v, 0);
      rd(4'h4, v); chk(v == 0, "R1 index after reset", v, 0);
      rd(4'h8, v); chk(v == 16, "R1 count after reset", v, 16);
      wr(4'h0, 32'h0);
      rd(4'h0, v); chk(v == 0, "R2 zero write does not arm", v, 0);
      rd(4'h8, v); chk(v == 16, "R5 idle count holds", v, 16);
      wr(4'h4, 32'hFFFF_FFF2);
      rd(4'h4, v); chk(v == 2, "R3 index field only", v, 2);
      rd(4'hC, v); chk(v == 0, "R6 restart reads zero", v, 0);
      // arm: count = 64, then one decrement per cycle
      wr(4'h0, 32'h1);
      rd(4'h8, v); chk(v == 64, "R4 load on arm", v, 64);
      rd(4'h8, v); chk(v == 63, "R5 decrement", v, 63);
      wr(4'h0, 32'h0);
      rd(4'h0, v); chk(v == 1, "R2 arm is sticky", v, 1);
      wr(4'hC, 32'h75);
      rd(4'h8, v); chk(v == 59, "R7 wrong key ignored", v, 59);
      wr(4'hC, 32'h0000_0176);
      rd(4'h8, v); chk(v == 57, "R7 key with extra bits ignored", v, 57);
      wr(4'hC, 32'h76);
      wr(4'h4, 32'h0);
      rd(4'h8, v); chk(v == 63, "R9 index change keeps count", v, 63);
      wait_pulse(n);
      chk(rst_req == 1, "R8 first expiry seen", rst_req, 1);
      @(negedge clk);
      chk(rst_req == 0, "R8 pulse one cycle", rst_req, 0);
      n = 1;
      while (!rst_req && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(n == 17, "R8 R9 interval uses new period", n, 17);
      @(negedge clk);
      rd(4'h8, v); chk(v == 15, "R8 reload continues", v, 15);
      wr(4'h4, 32'hF);
      wr(4'hC, 32'h76);
      rd(4'h8, v); chk(v == 32'd524288, "R4 largest index period", v, 524288);
      rd(4'h8, v); chk(v == 32'd524287, "R5 decrement large", v, 524287);
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      rd(4'h0, v); chk(v == 0, "R1 reset disarms", v, 0);
      rd(4'h8, v); chk(v == 16, "R1 reset count", v, 16);
      repeat (5) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule